// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire serial link: an enable line, a clock from the master, and one data line that changes direction for reads. A microcontroller uses it to write and read a small internal file of eight-bit registers. All serial inputs are taken in on the chip clock, and their edges are found by comparing registered samples. The data pad itself stays outside the block; the block drives separate data-out and output-enable signals for it.

Which serial clock edge launches data and which edge samples it is not fixed. On the first enable rising edge after power-down ends, the block notes the clock level. That choice holds until the next power-down. Every enable rising edge starts a fresh transaction. The first byte is a command: its top bit selects read (1) or write (0), and its low seven bits give the start address. Data bytes follow, MSB first. Writes commit one whole byte at a time. Reads turn the data line around straight after the command. The address steps up after every data byte, so bursts work while enable stays high.

Top module: `sif_slave`

## Requirements
- R1: After reset, the output-enable and the data output are low, and every register reads back as 0x00.
- R2: If the serial clock is low at the first enable rising edge after power-down, the slave samples on falling clock edges and launches on rising clock edges.
- R3: If the serial clock is high at that enable rising edge, the slave samples on rising clock edges and launches on falling clock edges.
- R4: Later enable rising edges do not change the edge choice, whatever the clock level is then; only power-down clears it.
- R5: Every enable rising edge aborts any transaction in progress and restarts command reception.
- R6: The first byte of a transaction is the command, MSB first: bit 7 = 1 means read and bit 7 = 0 means write; bits 6..0 are the register address.
- R7: A write data byte is stored only after its eighth bit has been sampled; a byte cut short by enable going low leaves the register unchanged.
- R8: On a read, output-enable stays low until the first launch edge after the eighth command bit; from that edge on, the slave drives one bit per launch edge, MSB first.
- R9: After each data byte, the address advances by one, for reads and for writes.
- R10: Output-enable is low whenever enable is low and throughout any write transaction.
- R11: Addresses 16 and above read as 0x00, and writes to them change no register.
- R12: Power-down clears the edge choice and releases output-enable at once; register contents are kept, and the edges are learned again at the next enable rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Power-down request, active high |
| sif_en_i | input | 1 | Transaction enable from the master |
| sif_clk_i | input | 1 | Serial clock from the master |
| sif_din_i | input | 1 | Data from the pad towards the slave |
| sif_dout_o | output | 1 | Data from the slave towards the pad |
| sif_oe_o | output | 1 | Pad output-enable; high while the slave drives |

## Verification
The hardest case to reach from the ports is an enable rising edge that happens while the clock sits at the opposite level, after the edges have already been learned. This must not change the edge choice. The bench produces it by lowering the clock while enable is low, giving a short enable pulse, and bringing the clock back before a full transaction in the learned mode. A wrongly relearned edge choice would corrupt the data read back. A power-down that arrives in the middle of a read burst is also covered, along with the aborted commands and the partly sent write bytes that R5 and R7 describe.

// File: rtl/sif_pkg.sv
package sif_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_WR   = 2'd2,
        PH_RD   = 2'd3
    } sif_phase_e;
endpackage

// File: rtl/sif_edge_cfg.sv
module sif_edge_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_i,
    input  logic en_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic en_lvl_o,
    output logic en_rise_o,
    output logic samp_o,
    output logic launch_o,
    output logic din_o,
    output logic pd_o
);
    typedef struct packed {
        logic sclk_s;
        logic sclk_p;
        logic en_s;
        logic en_p;
        logic din_s;
        logic pd_s;
        logic cfg_vld;
        logic mode;     // 0: sample falling, 1: sample rising
    } edge_st_t;

    edge_st_t q, d;
    logic clk_rise, clk_fall, active;

    assign clk_rise  = q.sclk_s & ~q.sclk_p;
    assign clk_fall  = ~q.sclk_s & q.sclk_p;
    assign active    = q.cfg_vld & q.en_s & ~q.pd_s;
    assign en_rise_o = q.en_s & ~q.en_p & ~q.pd_s;
    assign en_lvl_o  = q.en_s;
    assign samp_o    = active & (q.mode ? clk_rise : clk_fall);
    assign launch_o  = active & (q.mode ? clk_fall : clk_rise);
    assign din_o     = q.din_s;
    assign pd_o      = q.pd_s;

    always_comb begin
        d        = q;
        d.sclk_s = sclk_i;
        d.sclk_p = q.sclk_s;
        d.en_s   = en_i;
        d.en_p   = q.en_s;
        d.din_s  = din_i;
        d.pd_s   = pd_i;
        if (q.pd_s) begin
            d.cfg_vld = 1'b0;
        end else if (en_rise_o && !q.cfg_vld) begin
            d.cfg_vld = 1'b1;
            d.mode    = q.sclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic cfg_vld_w, mode_w, pd_w;
    assign cfg_vld_w = q.cfg_vld;
    assign mode_w    = q.mode;
    assign pd_w      = q.pd_s;

    // R4: once learned, the edge choice survives until power-down
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_vld_w && !pd_w) |=> (cfg_vld_w && $stable(mode_w)));

    // R12: power-down drops the learned configuration
    p_pd_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pd_w |=> !cfg_vld_w);
endmodule

// File: rtl/sif_regfile.sv
module sif_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_REGS - 1);

    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [DATA_W-1:0] regs_d [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we_i && (waddr_i <= TOP_ADDR))
            regs_d[waddr_i[IDX_W-1:0]] = wdata_i;
    end

    always_comb begin
        rdata_o = '0;
        if (raddr_i <= TOP_ADDR)
            rdata_o = regs_q[raddr_i[IDX_W-1:0]];
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= '0;
                else        regs_q[g] <= regs_d[g];
            end
        end
    endgenerate
endmodule

// File: rtl/sif_xfer.sv
module sif_xfer
    import sif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_i,
    input  logic              en_lvl_i,
    input  logic              en_rise_i,
    input  logic              samp_i,
    input  logic              launch_i,
    input  logic              din_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              dout_o,
    output logic              oe_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        sif_phase_e        phase;
        logic [DATA_W-2:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] tx;
        logic [CNT_W-1:0]  txcnt;
        logic              dout;
        logic              oe;
    } xfer_st_t;

    xfer_st_t q, d;
    logic [ADDR_W-1:0] cmd_addr;

    assign cmd_addr = {q.sh[DATA_W-3:0], din_i};
    assign raddr_o  = (q.phase == PH_CMD) ? cmd_addr : q.addr + 1'b1;
    assign waddr_o  = q.addr;
    assign wdata_o  = {q.sh, din_i};
    assign dout_o   = q.dout;
    assign oe_o     = q.oe;

    always_comb begin
        d    = q;
        we_o = 1'b0;
        if (pd_i || !en_lvl_i) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
            d.txcnt = '0;
        end else if (en_rise_i) begin
            d.phase = PH_CMD;
            d.oe    = 1'b0;
            d.cnt   = '0;
            d.txcnt = '0;
        end else begin
            case (q.phase)
                PH_CMD: if (samp_i) begin
                    d.sh  = {q.sh[DATA_W-3:0], din_i};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        d.cnt   = '0;
                        d.addr  = cmd_addr;
                        d.tx    = rdata_i;
                        d.phase = q.sh[DATA_W-2] ? PH_RD : PH_WR;
                    end
                end
                PH_WR: if (samp_i) begin
                    d.sh  = {q.sh[DATA_W-3:0], din_i};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        we_o   = 1'b1;
                        d.cnt  = '0;
                        d.addr = q.addr + 1'b1;
                    end
                end
                PH_RD: if (launch_i) begin
                    d.oe   = 1'b1;
                    d.dout = q.tx[DATA_W-1];
                    if (q.txcnt == LAST_BIT) begin
                        d.txcnt = '0;
                        d.tx    = rdata_i;
                        d.addr  = q.addr + 1'b1;
                    end else begin
                        d.tx    = {q.tx[DATA_W-2:0], 1'b0};
                        d.txcnt = q.txcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic in_rd;
    assign in_rd = (q.phase == PH_RD);

    // R10: pad released once enable is seen low
    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_lvl_i |=> !oe_o);

    // R10: never driving outside a read
    p_oe_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rd |-> !oe_o);

    // R8: data output only moves on a launch edge
    p_dout_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_i |=> $stable(dout_o));

    // R8: turnaround happens on a launch edge
    p_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(launch_i));
endmodule

// File: rtl/sif_slave.sv
module sif_slave #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_i,
    input  logic sif_en_i,
    input  logic sif_clk_i,
    input  logic sif_din_i,
    output logic sif_dout_o,
    output logic sif_oe_o
);
    localparam int ADDR_W = DATA_W - 1;

    logic              en_lvl, en_rise, samp, launch, din_s, pd_s, we;
    logic [ADDR_W-1:0] raddr, waddr;
    logic [DATA_W-1:0] rdata, wdata;

    sif_edge_cfg u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_i     (pd_i),
        .en_i     (sif_en_i),
        .sclk_i   (sif_clk_i),
        .din_i    (sif_din_i),
        .en_lvl_o (en_lvl),
        .en_rise_o(en_rise),
        .samp_o   (samp),
        .launch_o (launch),
        .din_o    (din_s),
        .pd_o     (pd_s)
    );

    sif_xfer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_i     (pd_s),
        .en_lvl_i (en_lvl),
        .en_rise_i(en_rise),
        .samp_i   (samp),
        .launch_i (launch),
        .din_i    (din_s),
        .rdata_i  (rdata),
        .raddr_o  (raddr),
        .we_o     (we),
        .waddr_o  (waddr),
        .wdata_o  (wdata),
        .dout_o   (sif_dout_o),
        .oe_o     (sif_oe_o)
    );

    sif_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );
endmodule

// File: tb/sif_slave_tb.sv
module sif_slave_tb;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n, pd, en, sclk, din;
    logic dout, oe;
    logic idle;
    logic oe_seen;
    logic [7:0] model [16];
    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sif_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_i      (pd),
        .sif_en_i  (en),
        .sif_clk_i (sclk),
        .sif_din_i (din),
        .sif_dout_o(dout),
        .sif_oe_o  (oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic start_t();
        sclk = idle; en = 1'b0; hp();
        en = 1'b1; hp();
    endtask

    task automatic stop_t();
        sclk = idle; en = 1'b0; hp();
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sclk = ~idle; din = v[7-i]; hp();
            if (oe) oe_seen = 1'b1;
            sclk = idle; hp();
            if (oe) oe_seen = 1'b1;
        end
    endtask

    task automatic recv_byte(output logic [7:0] v, output logic oe_ok);
        oe_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sclk = ~idle; hp();
            v[7-i] = dout;
            if (!oe) oe_ok = 1'b0;
            sclk = idle; hp();
        end
    endtask

    task automatic pd_cycle();
        sclk = idle; en = 1'b0; pd = 1'b1; hp();
        pd = 1'b0; hp();
    endtask

    task automatic write_regs(input logic [6:0] a, input int n, input logic [23:0] vals);
        start_t();
        send_bits({1'b0, a}, 8);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            logic [6:0] ai;
            b  = vals[23-8*i -: 8];
            ai = a + 7'(i);
            send_bits(b, 8);
            if (ai < 7'd16) model[ai[3:0]] = b;
        end
        stop_t();
    endtask

    task automatic read_check(input string req, input logic [6:0] a, input int n);
        logic [7:0] v;
        logic ok;
        start_t();
        send_bits({1'b1, a}, 8);
        for (int i = 0; i < n; i++) begin
            logic [6:0] ai;
            ai = a + 7'(i);
            recv_byte(v, ok);
            chk(req, {24'd0, v}, (ai < 7'd16) ? {24'd0, model[ai[3:0]]} : 32'd0);
            chk({req, " oe during read"}, {31'd0, ok}, 32'd1);
        end
        stop_t();
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", {31'd0, oe}, 32'd0);
        chk("R1 dout after reset", {31'd0, dout}, 32'd0);
        idle = 1'b0;
        pd_cycle();
        read_check("R1 regs cleared", 7'd0, 3);
    endtask

    task automatic t_mode_low();
        write_regs(7'd2, 3, 24'hA53CF0);
        read_check("R2 falling-sample burst R9", 7'd2, 3);
        write_regs(7'd9, 1, 24'h810000);
        read_check("R6 command address", 7'd9, 1);
        read_check("R9 burst across", 7'd8, 3);
    endtask

    task automatic t_oe_rules();
        logic [7:0] v;
        logic ok;
        oe_seen = 1'b0;
        write_regs(7'd7, 2, 24'h1E2D00);
        chk("R10 oe low in write", {31'd0, oe_seen}, 32'd0);
        start_t();
        send_bits(8'h83, 8);
        chk("R8 oe low before launch", {31'd0, oe}, 32'd0);
        recv_byte(v, ok);
        chk("R8 first read byte", {24'd0, v}, {24'd0, model[3]});
        chk("R8 oe driven", {31'd0, ok}, 32'd1);
        stop_t();
        chk("R10 oe low after enable low", {31'd0, oe}, 32'd0);
        read_check("R9 write burst stored", 7'd7, 2);
    endtask

    task automatic t_partial();
        start_t();
        send_bits(8'h05, 8);
        send_bits(8'hFF, 5);
        stop_t();
        read_check("R7 partial byte ignored", 7'd5, 1);
        start_t();
        send_bits(8'h85, 3);
        stop_t();
        write_regs(7'd5, 1, 24'h6E0000);
        read_check("R5 restart after abort", 7'd5, 1);
    endtask

    task automatic t_range();
        write_regs(7'h20, 1, 24'h770000);
        read_check("R11 high address reads zero", 7'h20, 1);
        read_check("R11 no alias write", 7'd0, 1);
        write_regs(7'd15, 2, 24'h99AB00);
        read_check("R11 burst past top", 7'd15, 2);
    endtask

    task automatic t_pd_high();
        idle = 1'b1;
        pd_cycle();
        write_regs(7'd4, 1, 24'h5A0000);
        read_check("R3 rising-sample mode", 7'd2, 3);
    endtask

    task automatic t_pd_mid();
        logic [7:0] v;
        logic ok;
        start_t();
        send_bits(8'h82, 8);
        recv_byte(v, ok);
        chk("R12 read before pd", {24'd0, v}, {24'd0, model[2]});
        pd = 1'b1; repeat (3) @(negedge clk);
        chk("R12 oe released by pd", {31'd0, oe}, 32'd0);
        en = 1'b0; sclk = idle; hp();
        pd = 1'b0; hp();
        read_check("R12 regs kept after pd", 7'd2, 2);
    endtask

    task automatic t_hold();
        en = 1'b0; sclk = ~idle; hp();
        en = 1'b1; hp();
        en = 1'b0; hp();
        sclk = idle; hp();
        write_regs(7'd6, 1, 24'hC30000);
        read_check("R4 edges held", 7'd6, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        rst_n = 1'b0; pd = 1'b1; en = 1'b0; sclk = 1'b0; din = 1'b0;
        idle = 1'b0; oe_seen = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        pd = 1'b0;
        t_reset();
        t_mode_low();
        t_oe_rules();
        t_partial();
        t_range();
        t_pd_high();
        t_pd_mid();
        t_hold();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule